// File: doc/BRIEF.md
# Codec control register file

This block is the bank of control registers that sits behind the command slots of an audio codec's serial link. The link front end decodes a command from each frame and presents it as a strobe with a read or write flag, a 7-bit register index and 16 bits of write data. The block keeps 16-bit registers at even indices. Each one has a default value and a mask of implemented bits. A read returns its answer one cycle after the command.

Some registers have side effects. Index 00h holds no data. A write to it with any value puts every register back to its default, and a read returns a fixed identification word. One register is guarded by a key register, and it opens only while the key holds the unlock word. Bit 15 of the power-down register drives the external amplifier power-down pin directly. Each mixer input gain register carries a mute bit, and the record gain register holds two 4-bit gain fields. Bit 12 of the power-down register requests a link sleep. The sleep takes effect once the current frame's slot 2 has ended. A warm-wake indication from the link front end ends the sleep and leaves every register as it was.

Top module: `codec_regfile`

## Requirements
- R1: After rst_n is released, the registers hold these defaults: 02h/04h/06h = 8000h, 0Ch/0Eh = 8008h, 10h..18h = 8808h, 1Ch = 8000h, 26h/70h/72h = 0000h. In the same state amp_off = 0, link_sleep = 0, mixer_mute = 7Fh and rd_valid = 0.
- R2: A read command (cmd_valid=1, cmd_write=0) makes rd_valid = 1 on the next cycle. rd_data then carries the stored value, with unimplemented bits read as 0. The implemented-bit masks are: 02h/04h/06h and 10h..18h keep 9F1Fh, 0Ch keeps 801Fh, 0Eh keeps 805Fh, 1Ch keeps 8F0Fh, 26h keeps FF00h, and 70h/72h keep all 16 bits.
- R3: A write of any value to index 00h returns every register to its R1 default. A read of index 00h returns the parameter ID_CODE.
- R4: amp_off equals bit 15 of register 26h, starting the cycle after the write.
- R5: mixer_mute[k] equals bit 15 of the register at index 0Ch+2k, for k = 0..6.
- R6: rec_gain_l is bits 11:8 of 1Ch, rec_gain_r is bits 3:0 and rec_mute is bit 15. The value 0F0Fh gives both gains their maximum of 15.
- R7: Register 72h is open only while 70h holds ABBAh. While it is locked, reads of 72h return 0000h and writes to it are ignored. Writing any other value to 70h locks it again, and the contents of 72h are kept.
- R8: Reads of odd or unimplemented indices return 0000h, and writes to them change no register.
- R9: A write to 26h with bit 12 set raises a sleep request. link_sleep rises on the cycle after the first frame_slot2_end pulse seen in or after the write cycle, and not before that pulse.
- R10: A warm_wake pulse clears link_sleep and any pending request on the next cycle and leaves all register contents and amp_off unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_index | input | 7 | Register index |
| cmd_wdata | input | 16 | Write data |
| frame_slot2_end | input | 1 | Pulse at the end of slot 2 of a frame |
| warm_wake | input | 1 | Pulse when a warm reset of the link has been detected |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| amp_off | output | 1 | External amplifier power-down pin |
| mixer_mute | output | 7 | Mute bits of the mixer input gain registers |
| rec_gain_l | output | 4 | Record gain, left |
| rec_gain_r | output | 4 | Record gain, right |
| rec_mute | output | 1 | Record mute |
| link_sleep | output | 1 | Link held in low-power state |

## Verification
The bench builds the block with ID_CODE set to 5A31h instead of its default, so an ID read shows the parameter and not a built-in constant. The unlock word, the sleep bit position and the seven mixer registers stay at their defaults. This brings every masked register, the lock/relock sequence, the sleep handshake against the slot-2 pulse and the full register reset within reach of one compact directed sequence.

// File: rtl/codec_regfile.sv
module codec_regfile #(
  parameter logic [15:0] ID_CODE      = 16'h4D21,
  parameter logic [15:0] UNLOCK_KEY   = 16'hABBA,
  parameter int          LINK_OFF_BIT = 12,
  parameter int          NMIX         = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [6:0]  cmd_index,
  input  logic [15:0] cmd_wdata,
  input  logic        frame_slot2_end,
  input  logic        warm_wake,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        amp_off,
  output logic [6:0]  mixer_mute,
  output logic [3:0]  rec_gain_l,
  output logic [3:0]  rec_gain_r,
  output logic        rec_mute,
  output logic        link_sleep
);
  localparam int MIX0  = 3;
  localparam int REC   = MIX0 + NMIX;
  localparam int PWR   = REC + 1;
  localparam int KEY   = PWR + 1;
  localparam int LCK   = KEY + 1;
  localparam int NSLOT = LCK + 1;
  localparam int SW    = $clog2(NSLOT);

  function automatic logic [SW:0] slot_of(input logic [6:0] idx);
    int i;
    i = int'(idx);
    if (i == 2 || i == 4 || i == 6) return {1'b1, SW'(i / 2 - 1)};
    if (i >= 12 && i < 12 + 2 * NMIX && (i % 2) == 0) return {1'b1, SW'(MIX0 + (i - 12) / 2)};
    if (i == 28)  return {1'b1, SW'(REC)};
    if (i == 38)  return {1'b1, SW'(PWR)};
    if (i == 112) return {1'b1, SW'(KEY)};
    if (i == 114) return {1'b1, SW'(LCK)};
    return '0;
  endfunction

  function automatic logic [15:0] mask_of(input int s);
    if (s == MIX0)     return 16'h801F;
    if (s == MIX0 + 1) return 16'h805F;
    if (s < REC)       return 16'h9F1F;
    if (s == REC)      return 16'h8F0F;
    if (s == PWR)      return 16'hFF00;
    return 16'hFFFF;
  endfunction

  function automatic logic [15:0] dflt_of(input int s);
    if (s < MIX0)                   return 16'h8000;
    if (s == MIX0 || s == MIX0 + 1) return 16'h8008;
    if (s < REC)                    return 16'h8808;
    if (s == REC)                   return 16'h8000;
    return 16'h0000;
  endfunction

  logic [15:0] regs [NSLOT];
  logic        wr, rd, hit, unlocked, wr_ok, lp_wr, pending;
  logic [SW-1:0] slot;

  assign wr       = cmd_valid & cmd_write;
  assign rd       = cmd_valid & ~cmd_write;
  assign {hit, slot} = slot_of(cmd_index);
  assign unlocked = (regs[KEY] == UNLOCK_KEY);
  assign wr_ok    = wr & hit & (unlocked | (int'(slot) != LCK));
  assign lp_wr    = wr & hit & (int'(slot) == PWR) & cmd_wdata[LINK_OFF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) regs[s] <= dflt_of(s);
    end else if (wr && cmd_index == 7'h00) begin
      for (int s = 0; s < NSLOT; s++) regs[s] <= dflt_of(s);
    end else if (wr_ok) begin
      regs[slot] <= cmd_wdata & mask_of(int'(slot));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) begin
        if (cmd_index == 7'h00)                      rd_data <= ID_CODE;
        else if (!hit)                               rd_data <= '0;
        else if (int'(slot) == LCK && !unlocked)     rd_data <= '0;
        else                                         rd_data <= regs[slot];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      link_sleep <= 1'b0;
    end else if (warm_wake) begin
      pending    <= 1'b0;
      link_sleep <= 1'b0;
    end else if (frame_slot2_end && (pending || lp_wr)) begin
      pending    <= 1'b0;
      link_sleep <= 1'b1;
    end else if (lp_wr) begin
      pending    <= 1'b1;
    end
  end

  assign amp_off    = regs[PWR][15];
  assign rec_gain_l = regs[REC][11:8];
  assign rec_gain_r = regs[REC][3:0];
  assign rec_mute   = regs[REC][15];

  for (genvar k = 0; k < 7; k++) begin : g_mute
    if (k < NMIX) begin : g_on
      assign mixer_mute[k] = regs[MIX0 + k][15];
    end else begin : g_off
      assign mixer_mute[k] = 1'b0;
    end
  end
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk #(
  parameter logic [15:0] ID_CODE = 16'h4D21
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_write,
  input logic [6:0]  cmd_index,
  input logic [15:0] cmd_wdata,
  input logic        frame_slot2_end,
  input logic        warm_wake,
  input logic        rd_valid,
  input logic [15:0] rd_data,
  input logic        amp_off,
  input logic [6:0]  mixer_mute,
  input logic [3:0]  rec_gain_l,
  input logic [3:0]  rec_gain_r,
  input logic        rec_mute,
  input logic        link_sleep
);
  a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !cmd_write));

  a_r3_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && cmd_index == 7'h00) |=> (rd_valid && rd_data == ID_CODE));

  a_r3_reset_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_index == 7'h00) |=> (!amp_off && mixer_mute == 7'h7F && rec_gain_l == 4'd0));

  a_r4_amp_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_index == 7'h26) |=> (amp_off == $past(cmd_wdata[15])));

  a_r8_odd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && cmd_index[0]) |=> (rd_data == 16'h0000));

  a_r9_sleep_after_slot2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_sleep) |-> $past(frame_slot2_end));

  a_r10_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    warm_wake |=> !link_sleep);

  a_r10_wake_keeps_amp: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_wake && !(cmd_valid && cmd_write)) |=> $stable(amp_off));
endmodule

bind codec_regfile codec_regfile_chk #(.ID_CODE(ID_CODE)) chk_i (.*);

// File: tb/codec_regfile_tb_top.sv
module codec_regfile_tb_top;
  localparam logic [15:0] ID = 16'h5A31;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0, frame_slot2_end = 0, warm_wake = 0;
  logic [6:0]  cmd_index = '0;
  logic [15:0] cmd_wdata = '0;
  logic rd_valid, amp_off, rec_mute, link_sleep;
  logic [15:0] rd_data;
  logic [6:0]  mixer_mute;
  logic [3:0]  rec_gain_l, rec_gain_r;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  codec_regfile #(.ID_CODE(ID)) dut_i (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic w, input logic [6:0] idx, input logic [15:0] d);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_write = w; cmd_index = idx; cmd_wdata = d;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_write = 0;
  endtask

  task automatic wr(input logic [6:0] idx, input logic [15:0] d);
    cmd(1'b1, idx, d);
  endtask

  task automatic rd(input logic [6:0] idx, input logic [15:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    cmd(1'b0, idx, 16'h0);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected rd_valid", 16'h1, 16'h0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #1;
    check("R1 rd_valid", {15'h0, rd_valid}, 16'h0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 amp_off", {15'h0, amp_off}, 16'h0);
    check("R1 link_sleep", {15'h0, link_sleep}, 16'h0);
    check("R1 mixer_mute", {9'h0, mixer_mute}, 16'h007F);
    rd(7'h02, 16'h8000, "R1 master default");
    rd(7'h0C, 16'h8008, "R1 0Ch default");
    rd(7'h18, 16'h8808, "R1 18h default");
    rd(7'h1C, 16'h8000, "R1 record default");
    rd(7'h26, 16'h0000, "R1 26h default");
    rd(7'h00, ID,       "R3 ID read");

    wr(7'h10, 16'hFFFF);
    rd(7'h10, 16'h9F1F, "R2 mask 10h");
    check("R5 mute bit2 set", {9'h0, mixer_mute}, 16'h007F);
    wr(7'h10, 16'h0808);
    check("R5 mute bit2 clear", {9'h0, mixer_mute}, 16'h007B);
    wr(7'h0E, 16'hFFFF);
    rd(7'h0E, 16'h805F, "R2 mask 0Eh");
    wr(7'h0C, 16'hFFFF);
    rd(7'h0C, 16'h801F, "R2 mask 0Ch");

    wr(7'h1C, 16'h0F0F);
    check("R6 max gain", {8'h0, rec_gain_l, rec_gain_r}, 16'h00FF);
    check("R6 mute off", {15'h0, rec_mute}, 16'h0);
    wr(7'h1C, 16'hFFFF);
    rd(7'h1C, 16'h8F0F, "R2 mask 1Ch");
    check("R6 mute on", {15'h0, rec_mute}, 16'h1);

    wr(7'h72, 16'h1234);
    rd(7'h72, 16'h0000, "R7 locked read");
    wr(7'h70, 16'hABBA);
    rd(7'h72, 16'h0000, "R7 locked write ignored");
    wr(7'h72, 16'h1234);
    rd(7'h72, 16'h1234, "R7 unlocked");
    rd(7'h70, 16'hABBA, "R7 key readback");
    wr(7'h70, 16'h0001);
    rd(7'h72, 16'h0000, "R7 relocked");
    wr(7'h72, 16'h5555);
    wr(7'h70, 16'hABBA);
    rd(7'h72, 16'h1234, "R7 contents kept");

    wr(7'h11, 16'hFFFF);
    rd(7'h11, 16'h0000, "R8 odd read");
    rd(7'h10, 16'h0808, "R8 odd write no effect");
    wr(7'h20, 16'hFFFF);
    rd(7'h20, 16'h0000, "R8 unimplemented");

    wr(7'h26, 16'h8000);
    check("R4 amp on", {15'h0, amp_off}, 16'h1);
    wr(7'h26, 16'h0000);
    check("R4 amp off", {15'h0, amp_off}, 16'h0);

    wr(7'h26, 16'h9000);
    repeat (3) @(posedge clk);
    #1 check("R9 no sleep before slot2", {15'h0, link_sleep}, 16'h0);
    @(posedge clk); #1 frame_slot2_end = 1;
    @(posedge clk); #1 frame_slot2_end = 0;
    check("R9 sleep after slot2", {15'h0, link_sleep}, 16'h1);
    @(posedge clk); #1 warm_wake = 1;
    @(posedge clk); #1 warm_wake = 0;
    check("R10 woken", {15'h0, link_sleep}, 16'h0);
    check("R10 amp kept", {15'h0, amp_off}, 16'h1);
    rd(7'h26, 16'h9000, "R10 register kept");
    rd(7'h10, 16'h0808, "R10 mixer kept");

    wr(7'h00, 16'h1234);
    check("R3 reset amp", {15'h0, amp_off}, 16'h0);
    check("R3 reset mute", {9'h0, mixer_mute}, 16'h007F);
    check("R3 reset rec", {8'h0, rec_gain_l, rec_gain_r}, 16'h0000);
    rd(7'h10, 16'h8808, "R3 reset 10h");
    rd(7'h70, 16'h0000, "R3 reset key");
    rd(7'h72, 16'h0000, "R3 reset locked");

    repeat (4) @(posedge clk);
    check("R2 all reads returned", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule